// File: doc/BRIEF.md
# Zero-turnaround pipelined burst SRAM

This block is a synthesizable behavioural model of a synchronous SRAM that can switch between read and write on every clock with no idle cycle. Every control, address and write-data input is captured on the rising edge of one clock. A cycle starts when the start input is low. With the start input high, the block makes the next address itself from a 2-bit burst counter. A static mode input selects either linear or interleaved burst order.

Reads and writes run through the same two-stage pipeline. Read data is registered and appears on the bus after the second enabled edge. Write data is sampled at the second enabled edge after its address. Because both directions use the same delay, alternating reads and writes keep the data bus busy on every cycle. An active-low clock enable freezes every register. A sleep input turns new cycles into deselects and switches the output off. An output enable gates the bus driver directly, without a clock.

Top module: `zbt_sram`

## Requirements
- R1: The block captures addr, din, start_n, we_n, be_n, cke_n and the three chip selects on the rising edge of clk. An operation is accepted only on an edge where cke_n is low.
- R2: If start_n is low on an enabled edge, a burst starts at addr. On an enabled edge with start_n high, the 2-bit burst count goes up by one, wrapping modulo 4. The address bits above the two lowest stay those of the starting address, and addr is ignored.
- R3: If burst_ilv is 0, the low two address bits are (start + count) mod 4. If burst_ilv is 1, they are start XOR count.
- R4: If we_n is low at the start edge, the burst is a write, otherwise it is a read. An advance edge keeps the type and byte enables of the start edge and ignores we_n and be_n.
- R5: be_n[i] low at the start edge lets lane i (din bits 8i+7:8i) be written. A lane whose bit is high keeps its stored byte.
- R6: While cke_n is high, a clock edge changes nothing: the burst state, the pipeline, the output register and the array all hold their values.
- R7: A start edge selects the device only when sel_a_n is low, sel_b is high and sel_c_n is low. Any other combination gives a deselect. Advancing after a deselect stays deselected and touches no data.
- R8: Read data for an address accepted at enabled edge k is on dq_out after enabled edge k+2. dq_drive is high only while that read result is held, oe_n is low and sleep is low.
- R9: Write data for an address accepted at enabled edge k is taken from din at enabled edge k+2. din on the other edges is ignored.
- R10: While sleep is high, start and advance edges are deselects and the output is off. Stored contents are kept.
- R11: A read and a write may be started on every enabled edge with no wait cycles. A read always returns the newest data, including byte-merged writes started on the edge just before it.
- R12: While rst_n is low at a clock edge, all pending operations are cleared, and dq_drive is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| start_n | input | 1 | Low: load address; high: advance burst |
| we_n | input | 1 | Low at start edge: write burst |
| be_n | input | 4 | Byte-lane write enables, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | Word address |
| din | input | 32 | Write data |
| dq_out | output | 32 | Read data (zero when not driven) |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
The bench sweeps every start address in both burst orders. A wrong wrap or order would send the reads to the wrong word in the block of four. Writes and reads alternate on every edge, each read aimed at the word written just before it. A design that resolved writes one stage late, or that sampled din on the wrong edge, would return stale or foreign bytes. Further sequences hold the clock enable high in the middle of a burst, present each bad chip-select pattern, and use sleep, advance with a flipped we_n, and oe_n high. A design that let any of these through would corrupt the array, change the burst type or drive the bus when it must not.

// File: rtl/zbt_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes a 2-bit burst counter; the block size is fixed at four words.
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // Low two address bits for burst beat cnt starting at offset start.
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] cnt,
                                                input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
// Address stage: captures a new cycle at a start edge or advances the burst.
// Assumes the mode input is held steady for the length of a burst.
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NBE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cke_n,
    input  logic           start_n,
    input  logic           we_n,
    input  logic [AW-1:0]  addr,
    input  logic [NBE-1:0] be_n,
    input  logic           sel_ok,
    input  logic           sleep,
    input  logic           burst_ilv,
    output op_kind_e       op_kind,
    output logic [AW-1:0]  op_addr,
    output logic [NBE-1:0] op_be
);

    op_kind_e       kind_q;
    logic [AW-1:0]  base_q;
    logic [1:0]     cnt_q;
    logic [NBE-1:0] be_q;

    // Load a fresh cycle or step the burst on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            be_q   <= '0;
        end else if (!cke_n) begin
            if (!start_n) begin
                base_q <= addr;
                cnt_q  <= '0;
                be_q   <= ~be_n;
                if (sel_ok && !sleep)
                    kind_q <= we_n ? OP_READ : OP_WRITE;
                else
                    kind_q <= OP_IDLE;
            end else begin
                cnt_q <= cnt_q + 2'd1;
                if (sleep)
                    kind_q <= OP_IDLE;
            end
        end
    end

    // Current beat address from base and burst count.
    always_comb begin
        op_kind = kind_q;
        op_be   = be_q;
        op_addr = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_q, burst_ilv)};
    end

    assert_adv_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && start_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

    assert_adv_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && start_n) |=> $stable(base_q));

    assert_type_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && start_n && !sleep) |=> (kind_q == $past(kind_q)));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(cnt_q) && $stable(kind_q) && $stable(base_q)));

    assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !start_n && !sel_ok) |=> (kind_q == OP_IDLE));

    assert_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && sleep) |=> (kind_q == OP_IDLE));

endmodule

// File: rtl/zbt_array.sv
// Lane-sliced storage plus the read output register.
// Resolves one operation per enabled edge, so program order is kept.
module zbt_array
    import zbt_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NBE = 4,
    parameter int BW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  op_kind_e          kind,
    input  logic [AW-1:0]     addr,
    input  logic [NBE-1:0]    be,
    input  logic [NBE*BW-1:0] wdata,
    output logic [NBE*BW-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NBE; g++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];
        logic [BW-1:0] out_q;

        // Byte write of this lane at the resolve stage.
        always_ff @(posedge clk) begin
            if (rst_n && !cke_n && kind == OP_WRITE && be[g])
                mem[addr] <= wdata[g*BW +: BW];
        end

        // Read this lane into the output register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q <= '0;
            else if (!cke_n && kind == OP_READ)
                out_q <= mem[addr];
        end

        assign rdata[g*BW +: BW] = out_q;
    end

    // Marks that the output register holds a fresh read result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else if (!cke_n)
            rvalid <= (kind == OP_READ);
    end

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rdata) && $stable(rvalid)));

endmodule

// File: rtl/zbt_sram.sv
// Top: chip-select decode, middle pipeline stage, bus driver.
// Assumes oe_n and sleep act without a clock on the driver.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NBE = 4,
    parameter int BW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              start_n,
    input  logic              we_n,
    input  logic [NBE-1:0]    be_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              burst_ilv,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [NBE*BW-1:0] din,
    output logic [NBE*BW-1:0] dq_out,
    output logic              dq_drive
);

    localparam int DW = NBE * BW;

    logic           sel_ok;
    op_kind_e       s0_kind, s1_kind;
    logic [AW-1:0]  s0_addr, s1_addr;
    logic [NBE-1:0] s0_be, s1_be;
    logic [DW-1:0]  rdata;
    logic           rvalid;

    // All three selects must agree at a start edge.
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zbt_burst_ctrl #(.AW(AW), .NBE(NBE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .start_n(start_n),
        .we_n(we_n), .addr(addr), .be_n(be_n), .sel_ok(sel_ok),
        .sleep(sleep), .burst_ilv(burst_ilv),
        .op_kind(s0_kind), .op_addr(s0_addr), .op_be(s0_be)
    );

    // Middle stage: delays each operation one enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_kind <= OP_IDLE;
            s1_addr <= '0;
            s1_be   <= '0;
        end else if (!cke_n) begin
            s1_kind <= s0_kind;
            s1_addr <= s0_addr;
            s1_be   <= s0_be;
        end
    end

    zbt_array #(.AW(AW), .NBE(NBE), .BW(BW)) u_array (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .kind(s1_kind),
        .addr(s1_addr), .be(s1_be), .wdata(din),
        .rdata(rdata), .rvalid(rvalid)
    );

    // Bus driver gated by output enable and sleep.
    always_comb begin
        dq_drive = rvalid && !oe_n && !sleep;
        dq_out   = dq_drive ? rdata : '0;
    end

    assert_read_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_kind == OP_READ) |=> rvalid);

    assert_nonread_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_kind != OP_READ) |=> !rvalid);

    assert_stage_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_n |=> (s1_kind == $past(s0_kind)));

    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(s1_kind) && $stable(s1_addr)));

endmodule

// File: tb/sim_zbt_sram.sv
// Self-checking bench with an arithmetic reference of the pipeline.
module sim_zbt_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0, start_n = 1'b0, we_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic        burst_ilv = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dq_out;
    logic        dq_drive;

    always #2 clk = ~clk;

    zbt_sram u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .start_n(start_n),
        .we_n(we_n), .be_n(be_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_ilv(burst_ilv), .sleep(sleep),
        .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out),
        .dq_drive(dq_drive)
    );

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_mem [64];
    int          bk_kind = 0;           // 0 idle, 1 read, 2 write
    logic [5:0]  bk_base = '0;
    logic [1:0]  bk_cnt = '0;
    logic [3:0]  bk_be = '0;
    int          q0_k = 0, q1_k = 0;
    logic [5:0]  q0_a = '0, q1_a = '0;
    logic [3:0]  q0_b = '0, q1_b = '0;
    logic        exp_vld = 1'b0;
    logic [31:0] exp_data = '0;
    logic [31:0] wseq = '0;
    int          badsel = 0;
    int          nt = 0;

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the reference, check outputs.
    task automatic tick(input logic ld, input logic wen, input logic [5:0] a,
                        input logic [3:0] ben, input logic selok,
                        input logic ce_n, input string tag);
        logic [1:0] ofs;
        int nk;
        nt++;
        start_n = ld; we_n = wen; addr = a; be_n = ben; cke_n = ce_n;
        if (selok) {sel_a_n, sel_b, sel_c_n} = 3'b010;
        else begin
            case (badsel % 3)
                0: {sel_a_n, sel_b, sel_c_n} = 3'b110;
                1: {sel_a_n, sel_b, sel_c_n} = 3'b000;
                default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
            endcase
            badsel++;
        end
        if (q1_k == 2 && !ce_n) begin
            wseq = wseq + 1;
            din = (wseq * 32'h9E3779B9) ^ 32'h0F1E2D3C;
        end else
            din = 32'hBAD00000 ^ nt;
        @(posedge clk);
        if (!ce_n) begin
            if (q1_k == 2) begin
                for (int i = 0; i < 4; i++)
                    if (q1_b[i]) m_mem[q1_a][i*8 +: 8] = din[i*8 +: 8];
                exp_vld = 1'b0;
            end else if (q1_k == 1) begin
                exp_vld = 1'b1;
                exp_data = m_mem[q1_a];
            end else
                exp_vld = 1'b0;
            if (!ld) begin
                nk = (selok && !sleep) ? (wen ? 1 : 2) : 0;
                bk_kind = nk; bk_base = a; bk_cnt = 2'd0; bk_be = ~ben;
            end else begin
                if (sleep) bk_kind = 0;
                bk_cnt = bk_cnt + 2'd1;
            end
            ofs = burst_ilv ? (bk_base[1:0] ^ bk_cnt) : (bk_base[1:0] + bk_cnt);
            q1_k = q0_k; q1_a = q0_a; q1_b = q0_b;
            q0_k = bk_kind; q0_a = {bk_base[5:2], ofs}; q0_b = bk_be;
        end
        @(negedge clk);
        chk(dq_drive == (exp_vld && !oe_n && !sleep), {tag, " drive"},
            {31'd0, dq_drive}, {31'd0, exp_vld && !oe_n && !sleep});
        if (exp_vld && !oe_n && !sleep)
            chk(dq_out == exp_data, {tag, " data"}, dq_out, exp_data);
    endtask

    task automatic flush(input string tag);
        tick(1'b0, 1'b1, 6'd0, 4'hF, 1'b0, 1'b0, tag);
        tick(1'b0, 1'b1, 6'd0, 4'hF, 1'b0, 1'b0, tag);
        tick(1'b0, 1'b1, 6'd0, 4'hF, 1'b0, 1'b0, tag);
    endtask

    task automatic rd_burst(input logic [5:0] a, input string tag);
        tick(1'b0, 1'b1, a, 4'hF, 1'b1, 1'b0, tag);
        for (int k = 0; k < 3; k++)
            tick(1'b1, 1'b0, ~a, 4'h0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dq_drive == 1'b0, "R12 reset", {31'd0, dq_drive}, 32'd0);
        rst_n = 1'b1;

        // R9 R1: fill the array with linear write bursts, one per block.
        for (int b = 0; b < 16; b++) begin
            tick(1'b0, 1'b0, 6'(b*4 + (b % 4)), 4'h0, 1'b1, 1'b0, "R9");
            for (int k = 0; k < 3; k++)
                tick(1'b1, 1'b1, 6'(63 - b), 4'hF, 1'b1, 1'b0, "R9");
        end
        flush("R1");

        // R2 R3: every start address in both orders.
        for (int m = 0; m < 2; m++) begin
            burst_ilv = m[0];
            for (int s = 0; s < 64; s++) rd_burst(6'(s), m ? "R3 ilv" : "R2 lin");
            flush("R3");
        end
        burst_ilv = 1'b0;

        // R11 R5: write then read the same word on the next edge.
        for (int i = 0; i < 32; i++) begin
            tick(1'b0, 1'b0, 6'(i*2), 4'(i), 1'b1, 1'b0, "R5");
            tick(1'b0, 1'b1, 6'(i*2), 4'hF, 1'b1, 1'b0, "R11");
        end
        flush("R11");

        // R4: advance with we_n low keeps the burst a read.
        rd_burst(6'd20, "R4");
        tick(1'b0, 1'b1, 6'd21, 4'hF, 1'b1, 1'b0, "R4");
        tick(1'b1, 1'b0, 6'd0, 4'h0, 1'b1, 1'b0, "R4");
        tick(1'b1, 1'b0, 6'd0, 4'h0, 1'b1, 1'b0, "R4");
        flush("R4");

        // R6: freeze in the middle of a write and read mix.
        tick(1'b0, 1'b0, 6'd30, 4'h5, 1'b1, 1'b0, "R6");
        tick(1'b0, 1'b1, 6'd12, 4'hF, 1'b1, 1'b0, "R6");
        for (int k = 0; k < 4; k++)
            tick(1'b0, 1'b0, 6'd12, 4'h0, 1'b1, 1'b1, "R6 hold");
        tick(1'b0, 1'b1, 6'd30, 4'hF, 1'b1, 1'b0, "R6");
        tick(1'b1, 1'b1, 6'd0, 4'hF, 1'b1, 1'b1, "R6 hold");
        flush("R6");
        rd_burst(6'd12, "R6");
        flush("R6");

        // R7: bad selects with write attempts, then read back.
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 1'b0, 6'd5, 4'h0, 1'b0, 1'b0, "R7");
            tick(1'b1, 1'b0, 6'd5, 4'h0, 1'b0, 1'b0, "R7");
        end
        flush("R7");
        rd_burst(6'd4, "R7");
        flush("R7");

        // R8: output enable high keeps the bus off.
        oe_n = 1'b1;
        rd_burst(6'd8, "R8 oe");
        oe_n = 1'b0;
        rd_burst(6'd8, "R8");
        flush("R8");

        // R10: sleep turns writes into deselects and silences reads.
        tick(1'b0, 1'b1, 6'd40, 4'hF, 1'b1, 1'b0, "R10");
        sleep = 1'b1;
        tick(1'b1, 1'b1, 6'd0, 4'hF, 1'b1, 1'b0, "R10");
        tick(1'b0, 1'b0, 6'd6, 4'h0, 1'b1, 1'b0, "R10");
        tick(1'b1, 1'b0, 6'd6, 4'h0, 1'b1, 1'b0, "R10");
        flush("R10");
        sleep = 1'b0;
        rd_burst(6'd4, "R10");
        flush("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule